// File: doc/BRIEF.md
# Sectored Two-Way Write-Back Cache Controller

This block is a small data cache between a word-wide CPU port and a block-wide memory port. Storage is organised as sets of two sectors. Each sector has one address tag that covers several blocks, while every block keeps its own valid and dirty flag. Each set holds one replacement bit. On every CPU access, the tags of both ways are compared in the same cycle that both ways' data are read. The way that hits then selects the word that goes to the output. A read hit therefore completes in the cycle it is presented.

On a miss where neither sector in the set owns the tag, the least recently used sector is the victim. Every dirty block in it is written back in ascending block order. The sector then takes the new tag, which invalidates all of its blocks, and only the referenced block is fetched. If a sector already owns the tag but the addressed block is invalid, only that block is fetched, and nothing is written back or re-tagged. Writes allocate on a miss and merge the word into the fetched block. A mode input selects write-through, where the updated block is also sent to memory and stays clean.

The CPU holds its request until `cpu_ready_o` is high for one cycle. The memory side holds `mem_req_o`, `mem_we_o` and `mem_addr_o` until the cycle `mem_ack_i` is high. On a read acknowledge, `mem_rdata_i` carries the block.

Top module: `sectored_cache`

## Requirements
- R1: The word address is split as bit 0 word in block, bit 1 block in sector, bits 4:2 set and bits 11:5 tag. The memory block address is the word address shifted right by one, and word 0 of a block sits in bits 31:0 of the block data.
- R2: When the addressed block is valid in the way whose tag matches, a read completes in the same cycle with that word and no memory request.
- R3: When a valid sector owns the tag but the addressed block is invalid, exactly one block fetch is made, with no write-back and no re-tag, so the sector's other blocks keep hitting.
- R4: When no sector owns the tag, the victim sector's valid dirty blocks are each written back once, and then the addressed block is fetched. Read data is returned in the cycle of the fetch acknowledge.
- R5: Re-tagging a sector invalidates all of its blocks, so a block that belonged to the old tag cannot hit under the new one.
- R6: Within a set, the victim is the way that was not used by the most recent hit or fill in that set.
- R7: With write-through off, a write hit updates the word, marks the block dirty and makes no memory access. The data later reaches memory when the block is evicted.
- R8: A write miss fetches the block, merges the written word into it and marks it dirty. The other word of the block holds the memory value.
- R9: With write-through on, every write ends with one block write of the updated block to memory, and the block stays clean. A later eviction of that block therefore writes nothing.
- R10: `cpu_ready_o` stays low from the detection of a miss until the access finishes. A memory request holds its address and direction until acknowledged.
- R11: Reset clears every valid bit, every dirty bit and the replacement state, so a previously cached address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wt_en_i | input | 1 | Write-through mode when high |
| cpu_req_i | input | 1 | CPU access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 12 | Word address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_rdata_o | output | 32 | Read word, valid while ready is high on a read |
| cpu_ready_o | output | 1 | Access completes this cycle |
| mem_req_o | output | 1 | Memory block request |
| mem_we_o | output | 1 | 1 = block write, 0 = block fetch |
| mem_addr_o | output | 11 | Block address |
| mem_wdata_o | output | 64 | Block write data |
| mem_rdata_i | input | 64 | Block fetch data |
| mem_ack_i | input | 1 | Memory transfer completes this cycle |

## Verification
The hardest state to reach is a victim sector that has both blocks dirty, while its neighbour sector in the set is the more recently used way. Only then does a single miss cause two write-backs before the fetch. The stimulus first creates that state by write misses on both blocks of one sector. It then uses a fill of the other way and a third tag to force the eviction. A stale-block read after a re-tag, and a clean eviction after write-through writes, are built the same way. Each scenario is checked through transfer counts and through data returned from the bench's memory model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_RETAG,
    ST_FILL,
    ST_WTHRU
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int SETS   = 8,
  parameter int BLOCKS = 2,
  parameter int TAG_W  = 7,
  localparam int SET_W = $clog2(SETS),
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic [TAG_W-1:0]  way_tag_o [2],
  output logic [1:0]        blk_vld_o,
  output logic [1:0]        sec_vld_o,
  output logic              lru_way_o,
  input  logic              way_i,
  output logic [BLOCKS-1:0] sec_vd_o,
  input  logic              retag_i,
  input  logic [TAG_W-1:0]  new_tag_i,
  input  logic              fill_i,
  input  logic              fill_dirty_i,
  input  logic              mark_dirty_i,
  input  logic              mark_way_i,
  input  logic              touch_i,
  input  logic              touch_way_i
);
  logic [TAG_W-1:0]  tag_q [SETS][2];
  logic [BLOCKS-1:0] vld_q [SETS][2];
  logic [BLOCKS-1:0] dty_q [SETS][2];
  logic [SETS-1:0]   lru_q;  // way to evict next

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < 2; w++) begin
          tag_q[s][w] <= '0;
          vld_q[s][w] <= '0;
          dty_q[s][w] <= '0;
        end
      end
      lru_q <= '0;
    end else begin
      if (retag_i) begin
        tag_q[set_i][way_i] <= new_tag_i;
        vld_q[set_i][way_i] <= '0;
        dty_q[set_i][way_i] <= '0;
      end
      if (fill_i) begin
        vld_q[set_i][way_i][blk_i] <= 1'b1;
        dty_q[set_i][way_i][blk_i] <= fill_dirty_i;
      end
      if (mark_dirty_i) dty_q[set_i][mark_way_i][blk_i] <= 1'b1;
      if (touch_i) lru_q[set_i] <= ~touch_way_i;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_way
    assign way_tag_o[g] = tag_q[set_i][g];
    assign blk_vld_o[g] = vld_q[set_i][g][blk_i];
    assign sec_vld_o[g] = |vld_q[set_i][g];
  end

  assign lru_way_o = lru_q[set_i];
  assign sec_vd_o  = vld_q[set_i][way_i] & dty_q[set_i][way_i];

  // R5
  retag_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retag_i |=> (vld_q[$past(set_i)][$past(way_i)] == '0));
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int SETS   = 8,
  parameter int BLOCKS = 2,
  parameter int WORDS  = 2,
  parameter int DATA_W = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic [SET_W-1:0]  set_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic [LINE_W-1:0] line_o [2],
  input  logic              way_b_i,
  input  logic [BLK_W-1:0]  blk_b_i,
  output logic [LINE_W-1:0] line_b_o,
  input  logic              wr_i,
  input  logic              wr_way_i,
  input  logic [WORDS-1:0]  wr_mask_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  logic [LINE_W-1:0] mem_q [SETS][2][BLOCKS];

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int k = 0; k < WORDS; k++) begin
        if (wr_mask_i[k])
          mem_q[set_i][wr_way_i][blk_i][k*DATA_W +: DATA_W] <= wr_line_i[k*DATA_W +: DATA_W];
      end
    end
  end

  // both ways read in parallel with the tag compare
  for (genvar g = 0; g < 2; g++) begin : g_rd
    assign line_o[g] = mem_q[set_i][g][blk_i];
  end

  assign line_b_o = mem_q[set_i][way_b_i][blk_b_i];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int BLOCKS = 2,
  localparam int BLK_W = $clog2(BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wt_i,
  input  logic              hit_i,
  input  logic              hit_way_i,
  input  logic              sec_hit_i,
  input  logic              sec_way_i,
  input  logic              lru_way_i,
  input  logic [BLOCKS-1:0] vd_i,
  input  logic              mem_ack_i,
  output sc_state_e         state_o,
  output logic              way_o,
  output logic [BLK_W-1:0]  fl_blk_o,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              retag_o,
  output logic              fill_o,
  output logic              fill_dirty_o,
  output logic              mark_dirty_o,
  output logic              touch_o,
  output logic              touch_way_o,
  output logic              dwr_o,
  output logic              dwr_way_o,
  output logic              dwr_fill_o
);
  sc_state_e        state_q, state_d;
  logic             way_q, way_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      way_q   <= 1'b0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      way_q   <= way_d;
      blk_q   <= blk_d;
    end
  end

  always_comb begin
    state_d      = state_q;
    way_d        = way_q;
    blk_d        = blk_q;
    adv          = 1'b0;
    ready_o      = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    retag_o      = 1'b0;
    fill_o       = 1'b0;
    fill_dirty_o = 1'b0;
    mark_dirty_o = 1'b0;
    touch_o      = 1'b0;
    touch_way_o  = 1'b0;
    dwr_o        = 1'b0;
    dwr_way_o    = 1'b0;
    dwr_fill_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (hit_i) begin
            touch_o     = 1'b1;
            touch_way_o = hit_way_i;
            if (!we_i) begin
              ready_o = 1'b1;
            end else begin
              dwr_o     = 1'b1;
              dwr_way_o = hit_way_i;
              if (wt_i) begin
                way_d   = hit_way_i;
                state_d = ST_WTHRU;
              end else begin
                mark_dirty_o = 1'b1;
                ready_o      = 1'b1;
              end
            end
          end else if (sec_hit_i) begin
            way_d   = sec_way_i;
            state_d = ST_FILL;
          end else begin
            way_d   = lru_way_i;
            blk_d   = '0;
            state_d = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        if (vd_i[blk_q]) begin
          mem_req_o = 1'b1;
          mem_we_o  = 1'b1;
          adv       = mem_ack_i;
        end else begin
          adv = 1'b1;
        end
        if (adv) begin
          if (blk_q == BLK_W'(BLOCKS - 1)) state_d = ST_RETAG;
          else blk_d = blk_q + 1'b1;
        end
      end
      ST_RETAG: begin
        retag_o = 1'b1;
        state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          dwr_o        = 1'b1;
          dwr_way_o    = way_q;
          dwr_fill_o   = 1'b1;
          fill_o       = 1'b1;
          fill_dirty_o = we_i & ~wt_i;
          touch_o      = 1'b1;
          touch_way_o  = way_q;
          if (we_i && wt_i) begin
            state_d = ST_WTHRU;
          end else begin
            ready_o = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_ack_i) begin
          ready_o = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o  = state_q;
  assign way_o    = way_q;
  assign fl_blk_o = blk_q;

  // R10
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |-> !ready_o);

  // R4
  retag_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RETAG) |=> (state_q == ST_FILL) && mem_req_o && !mem_we_o);
endmodule

// File: rtl/sectored_cache.sv
module sectored_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int BLOCKS = 2,
  parameter int WORDS  = 2,
  localparam int WORD_W  = $clog2(WORDS),
  localparam int MADDR_W = ADDR_W - WORD_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wt_en_i,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  output logic               cpu_ready_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  input  logic [LINE_W-1:0]  mem_rdata_i,
  input  logic               mem_ack_i
);
  localparam int BLK_W = $clog2(BLOCKS);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - WORD_W - BLK_W - SET_W;

  logic [WORD_W-1:0] cpu_word;
  logic [BLK_W-1:0]  cpu_blk;
  logic [SET_W-1:0]  cpu_set;
  logic [TAG_W-1:0]  cpu_tag;

  assign cpu_word = cpu_addr_i[WORD_W-1:0];
  assign cpu_blk  = cpu_addr_i[WORD_W +: BLK_W];
  assign cpu_set  = cpu_addr_i[WORD_W+BLK_W +: SET_W];
  assign cpu_tag  = cpu_addr_i[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0]  way_tag [2];
  logic [1:0]        blk_vld, sec_vld, tag_eq, hit_w, sec_w;
  logic              lru_way;
  logic [BLOCKS-1:0] sec_vd;
  logic [LINE_W-1:0] way_line [2];
  logic [LINE_W-1:0] line_b;
  logic              hit, hit_way, sec_hit, sec_way;

  sc_state_e         state;
  logic              way_q;
  logic [BLK_W-1:0]  fl_blk;
  logic retag, fill, fill_dirty, mark_dirty, touch, touch_way;
  logic dwr, dwr_way, dwr_fill;

  // late select: tag compare beside data read
  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign tag_eq[g] = (way_tag[g] == cpu_tag);
    assign hit_w[g]  = tag_eq[g] & blk_vld[g];
    assign sec_w[g]  = tag_eq[g] & sec_vld[g];
  end
  assign hit     = |hit_w;
  assign hit_way = hit_w[1];
  assign sec_hit = |sec_w;
  assign sec_way = sec_w[1];

  sc_tag_store #(.SETS(SETS), .BLOCKS(BLOCKS), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (cpu_set),
    .blk_i        (cpu_blk),
    .way_tag_o    (way_tag),
    .blk_vld_o    (blk_vld),
    .sec_vld_o    (sec_vld),
    .lru_way_o    (lru_way),
    .way_i        (way_q),
    .sec_vd_o     (sec_vd),
    .retag_i      (retag),
    .new_tag_i    (cpu_tag),
    .fill_i       (fill),
    .fill_dirty_i (fill_dirty),
    .mark_dirty_i (mark_dirty),
    .mark_way_i   (hit_way),
    .touch_i      (touch),
    .touch_way_i  (touch_way)
  );

  logic [BLK_W-1:0]  blk_b;
  logic [LINE_W-1:0] wr_line, merged;
  logic [WORDS-1:0]  wr_mask;

  assign blk_b = (state == ST_FLUSH) ? fl_blk : cpu_blk;

  always_comb begin
    merged = mem_rdata_i;
    if (cpu_we_i) merged[cpu_word*DATA_W +: DATA_W] = cpu_wdata_i;
  end

  assign wr_line = dwr_fill ? merged : {WORDS{cpu_wdata_i}};
  assign wr_mask = dwr_fill ? {WORDS{1'b1}} : (WORDS'(1) << cpu_word);

  sc_data_store #(.SETS(SETS), .BLOCKS(BLOCKS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .set_i     (cpu_set),
    .blk_i     (cpu_blk),
    .line_o    (way_line),
    .way_b_i   (way_q),
    .blk_b_i   (blk_b),
    .line_b_o  (line_b),
    .wr_i      (dwr),
    .wr_way_i  (dwr_way),
    .wr_mask_i (wr_mask),
    .wr_line_i (wr_line)
  );

  sc_ctrl #(.BLOCKS(BLOCKS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .wt_i         (wt_en_i),
    .hit_i        (hit),
    .hit_way_i    (hit_way),
    .sec_hit_i    (sec_hit),
    .sec_way_i    (sec_way),
    .lru_way_i    (lru_way),
    .vd_i         (sec_vd),
    .mem_ack_i    (mem_ack_i),
    .state_o      (state),
    .way_o        (way_q),
    .fl_blk_o     (fl_blk),
    .ready_o      (cpu_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .retag_o      (retag),
    .fill_o       (fill),
    .fill_dirty_o (fill_dirty),
    .mark_dirty_o (mark_dirty),
    .touch_o      (touch),
    .touch_way_o  (touch_way),
    .dwr_o        (dwr),
    .dwr_way_o    (dwr_way),
    .dwr_fill_o   (dwr_fill)
  );

  logic [LINE_W-1:0] out_line;
  assign out_line    = (state == ST_FILL) ? mem_rdata_i : way_line[hit_way];
  assign cpu_rdata_o = out_line[cpu_word*DATA_W +: DATA_W];

  assign mem_addr_o  = (state == ST_FLUSH) ? {way_tag[way_q], cpu_set, fl_blk}
                                           : {cpu_tag, cpu_set, cpu_blk};
  assign mem_wdata_o = line_b;

  // R2
  read_hit_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && hit && state == ST_IDLE) |-> (cpu_ready_o && !mem_req_o));

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/sim_sectored_cache.sv
module sim_sectored_cache;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wt_en_i = 1'b0;
  logic        cpu_req_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [11:0] cpu_addr_i = '0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic        cpu_ready_o;
  logic        mem_req_o, mem_we_o;
  logic [10:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sectored_cache u0 (
    .clk_i, .rst_ni, .wt_en_i, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdata_o, .cpu_ready_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i
  );

  int n_chk = 0, n_fail = 0, n_fill = 0, n_wb = 0;
  logic [10:0] last_fill_addr = '0;
  logic [31:0] bmem [int];
  logic [31:0] gold [int];
  logic [31:0] exp_q [$];
  string       nm_q [$];

  function automatic logic [11:0] mk(int tg, int st, int bk, int wd);
    return {tg[6:0], st[2:0], bk[0], wd[0]};
  endfunction

  function automatic logic [31:0] initv(int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0007);
  endfunction

  function automatic logic [31:0] mem_rd(int a);
    return bmem.exists(a) ? bmem[a] : initv(a);
  endfunction

  function automatic logic [31:0] gold_rd(int a);
    return gold.exists(a) ? gold[a] : initv(a);
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // memory model: two-cycle latency, one-cycle acknowledge
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
        lat = 0;
      end else if (mem_req_o && rst_ni) begin
        lat++;
        if (lat == 2) begin
          if (mem_we_o) begin
            bmem[int'(mem_addr_o)*2]   = mem_wdata_o[31:0];
            bmem[int'(mem_addr_o)*2+1] = mem_wdata_o[63:32];
            n_wb++;
          end else begin
            mem_rdata_i = {mem_rd(int'(mem_addr_o)*2+1), mem_rd(int'(mem_addr_o)*2)};
            last_fill_addr = mem_addr_o;
            n_fill++;
          end
          mem_ack_i = 1'b1;
        end
      end else begin
        lat = 0;
      end
    end
  end

  // monitor: pops expected read data when a read completes
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (cpu_req_i && cpu_ready_o && !cpu_we_i) begin
        logic [31:0] e;
        string n;
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected read completion R2", cpu_rdata_o, '0);
        end else begin
          e = exp_q.pop_front();
          n = nm_q.pop_front();
          check(cpu_rdata_o == e, n, cpu_rdata_o, e);
        end
      end
    end
  end

  task automatic op(bit we, logic [11:0] a, logic [31:0] d, int ef, int ew, string nm);
    int f0 = n_fill;
    int w0 = n_wb;
    int waits = 0;
    @(negedge clk_i);
    cpu_req_i   = 1'b1;
    cpu_we_i    = we;
    cpu_addr_i  = a;
    cpu_wdata_i = d;
    if (we) gold[int'(a)] = d;
    else begin
      exp_q.push_back(gold_rd(int'(a)));
      nm_q.push_back({nm, " data"});
    end
    forever begin
      #1;
      if (cpu_ready_o) break;
      waits++;
      @(negedge clk_i);
    end
    @(posedge clk_i);
    #1;
    cpu_req_i = 1'b0;
    check(n_fill - f0 == ef, {nm, " fetch count"}, n_fill - f0, ef);
    check(n_wb - w0 == ew, {nm, " write-back count"}, n_wb - w0, ew);
    if (ef + ew > 0) check(waits > 0, {nm, " R10 stalled"}, waits, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(!cpu_ready_o && !mem_req_o, "R11 reset outputs idle", {cpu_ready_o, mem_req_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 R4 cold miss, R1 address of the fetch
    op(0, mk(1,2,0,0), 0, 1, 0, "R11 R4 cold read miss");
    check(last_fill_addr == mk(1,2,0,0) >> 1, "R1 fetch block address",
          32'(last_fill_addr), 32'(mk(1,2,0,0) >> 1));
    op(0, mk(1,2,0,1), 0, 0, 0, "R2 read hit other word");
    op(0, mk(1,2,1,0), 0, 1, 0, "R3 tag match, block invalid");
    op(0, mk(1,2,0,0), 0, 0, 0, "R3 first block still hits");
    op(1, mk(1,2,0,0), 32'hDEAD_0001, 0, 0, "R7 write hit");
    op(0, mk(1,2,0,0), 0, 0, 0, "R7 write hit read back");
    op(0, mk(2,2,0,0), 0, 1, 0, "R6 second tag takes other way");
    op(0, mk(1,2,1,1), 0, 0, 0, "R6 touch first sector");
    op(0, mk(3,2,1,1), 0, 1, 0, "R6 victim is clean second sector");
    op(0, mk(4,2,0,1), 0, 1, 1, "R4 R7 evict dirty sector");
    op(0, mk(4,2,1,0), 0, 1, 0, "R5 stale block misses after retag");
    op(0, mk(1,2,0,0), 0, 1, 0, "R7 written-back word returns");

    op(1, mk(1,4,0,0), 32'hBEEF_0010, 1, 0, "R8 write miss allocates");
    op(0, mk(1,4,0,1), 0, 0, 0, "R8 other word from memory");
    op(0, mk(1,4,0,0), 0, 0, 0, "R8 merged word");
    op(1, mk(1,4,1,1), 32'hBEEF_0011, 1, 0, "R8 R3 write miss second block");
    op(0, mk(2,4,0,0), 0, 1, 0, "R6 fill other way");
    op(0, mk(3,4,0,0), 0, 1, 2, "R4 both dirty blocks flushed");
    op(0, mk(1,4,1,1), 0, 1, 0, "R4 flushed block reads back");

    wt_en_i = 1'b1;
    op(1, mk(5,5,0,0), 32'hFACE_0020, 1, 1, "R9 write-through miss");
    op(1, mk(5,5,0,1), 32'hFACE_0021, 0, 1, "R9 write-through hit");
    op(0, mk(5,5,0,0), 0, 0, 0, "R9 write-through data cached");
    wt_en_i = 1'b0;
    op(0, mk(6,5,1,0), 0, 1, 0, "R6 fill other way in set 5");
    op(0, mk(7,5,0,0), 0, 1, 0, "R9 clean eviction writes nothing");
    op(0, mk(5,5,0,1), 0, 1, 0, "R9 memory holds written-through word");

    op(0, mk(1,6,0,0), 0, 1, 0, "R11 fill before reset");
    op(0, mk(1,6,0,0), 0, 0, 0, "R11 hit before reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    op(0, mk(1,6,0,0), 0, 1, 0, "R11 reset cleared valid bits");

    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, "R2 all reads completed", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule